// File: doc/BRIEF.md
# Carry-Pipelined Multi-Operand Adder Tree

This block adds a set of unsigned operands and returns their full-precision sum. The operands are combined pairwise in a balanced binary tree of two-input adders. Every adder in the tree is cut into a chain of narrow slices. Each slice adds a few bits and registers its carry for the slice above, so the clock period is bounded by one narrow addition rather than a full-width carry chain.

On entry, each operand is skewed: its higher slices are delayed by one cycle per slice position. Through the whole tree the data then moves as a diagonal wavefront, with the low slices one cycle ahead of the high ones. At the root a deskew stage realigns the slices. A complete sum appears a fixed number of cycles after its operand set was accepted. A valid flag travels alongside the data. A new operand set may be presented on every clock cycle, and the block never stalls.

At the default parameters, five 9-bit operands (three slices of three bits) give a 12-bit sum with a latency of six cycles.

Top module: `sliced_sum_tree`

## Requirements
- R1: When `sum_valid` is high, `sum_data` equals the unsigned sum of all N_OPS operands of the corresponding set, with no truncation. Operand i is read from `in_ops` bits [i*OP_W +: OP_W], where OP_W = SLICE_W*N_SLICES. The sum is OP_W + ceil(log2 N_OPS) bits wide.
- R2: A set sampled with `in_valid` high on rising edge e produces `sum_valid` high, with its sum, immediately after edge e+LAT-1, where LAT = ceil(log2 N_OPS) + N_SLICES (6 at defaults).
- R3: A set may be accepted on every cycle. Back-to-back sets return back-to-back results in the order they were accepted, and every accepted set returns exactly one result.
- R4: A cycle with `in_valid` low produces `sum_valid` low LAT cycles later. The `in_ops` value on that cycle has no effect on the sums of neighbouring valid sets.
- R5: Carries cross every slice boundary. Five all-ones operands give 2555, and 63 + 1 (a ripple from the lowest slice through the middle slice into the top slice) gives 64.
- R6: Reset is synchronous and active low. `sum_valid` stays low while `rst_n` is low, and `in_valid` is ignored during reset. After release, no set accepted before or during reset ever produces a result.
- R7: Every operand position contributes with weight one. This includes the operand that has no partner at a tree level and is carried up by a plain register (position 4 at defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_ops` in this cycle |
| in_ops | input | N_OPS*SLICE_W*N_SLICES | Packed operands, operand 0 in the lowest bits |
| sum_valid | output | 1 | Qualifies `sum_data` |
| sum_data | output | SLICE_W*N_SLICES+ceil(log2 N_OPS) | Full-width sum of one operand set |

## Verification
The bench targets carries that must cross a slice boundary one cycle late, such as 63 + 1 and all-ones operands. A design that registered a carry into the wrong cycle, or dropped it, would return a sum that is low by a multiple of 8 or 64. It drives one operand at a time into each position. This exposes a lost or doubled unpaired operand at a level with an odd node count, which would show up as 0 or twice the value. Bubble patterns carrying garbage operands, and a reset asserted while sets are in flight, catch a valid flag that is misaligned by a cycle, a result from a set that should have been discarded, or a result returned a cycle early or late.

// File: rtl/sst_pkg.sv
// Shared helpers for the sliced adder tree.
// Assumes: operand count of at least two.
package sst_pkg;

    // Number of nodes at a given tree level (level 0 = leaves).
    function automatic int level_nodes(input int n_leaf, input int lvl);
        int c;
        c = n_leaf;
        for (int i = 0; i < lvl; i++) begin
            c = (c + 1) / 2;
        end
        return c;
    endfunction

endpackage

// File: rtl/sst_skew_in.sv
// Input skew for one operand: slice j is delayed by j+1 cycles, so the
// operand leaves as a diagonal wavefront with the low slice first.
// Assumes: WORD_W > SLICE_W*N_SLICES; bits above the operand are zero.
module sst_skew_in #(
    parameter int SLICE_W  = 3,
    parameter int N_SLICES = 3,
    parameter int WORD_W   = 12
) (
    input  logic                          clk,
    input  logic [SLICE_W*N_SLICES-1:0]   op,
    output logic [WORD_W-1:0]             word
);
    localparam int OP_W = SLICE_W * N_SLICES;

    for (genvar j = 0; j < N_SLICES; j++) begin : g_sl
        logic [SLICE_W-1:0] dly_q [j+1];

        // Delay line of depth j+1 for slice j.
        always_ff @(posedge clk) begin
            dly_q[0] <= op[j*SLICE_W +: SLICE_W];
            for (int m = 1; m <= j; m++) begin
                dly_q[m] <= dly_q[m-1];
            end
        end

        assign word[j*SLICE_W +: SLICE_W] = dly_q[j];
    end

    assign word[WORD_W-1:OP_W] = '0;

endmodule

// File: rtl/sst_node.sv
// One two-input tree adder working on skewed words. Slice j adds its
// operand slices plus the carry registered from slice j-1 in the
// previous cycle, which belongs to the same operand set because of the
// skew. The top slice is wide enough to absorb all tree growth, so it
// produces no carry.
// Assumes: N_SLICES >= 2; the sum of a and b fits in WORD_W bits.
module sst_node #(
    parameter int SLICE_W  = 3,
    parameter int N_SLICES = 3,
    parameter int WORD_W   = 12
) (
    input  logic              clk,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y
);
    localparam int TOP_LO = (N_SLICES - 1) * SLICE_W;
    localparam int TOP_W  = WORD_W - TOP_LO;

    logic [WORD_W-1:0]   sum_d;
    logic [WORD_W-1:0]   sum_q;
    logic [N_SLICES-2:0] cy_d;
    logic [N_SLICES-2:0] cy_q;

    for (genvar j = 0; j < N_SLICES - 1; j++) begin : g_low
        logic             cin;
        logic [SLICE_W:0] part;

        if (j == 0) begin : g_first
            assign cin = 1'b0;
        end else begin : g_rest
            assign cin = cy_q[j-1];
        end

        // Narrow slice addition with carry out.
        assign part = {1'b0, a[j*SLICE_W +: SLICE_W]}
                    + {1'b0, b[j*SLICE_W +: SLICE_W]}
                    + {{SLICE_W{1'b0}}, cin};
        assign sum_d[j*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
        assign cy_d[j] = part[SLICE_W];
    end

    // Top slice: absorbs the last carry, never overflows.
    assign sum_d[WORD_W-1:TOP_LO] = a[WORD_W-1:TOP_LO] + b[WORD_W-1:TOP_LO]
                                  + {{(TOP_W-1){1'b0}}, cy_q[N_SLICES-2]};

    // Register slice sums and carries for the next wavefront step.
    always_ff @(posedge clk) begin
        sum_q <= sum_d;
        cy_q  <= cy_d;
    end

    assign y = sum_q;

endmodule

// File: rtl/sst_delay.sv
// Single register stage that carries an unpaired skewed word up one
// tree level, keeping it aligned with the adders beside it.
// Assumes: nothing beyond a free-running clock.
module sst_delay #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    // One cycle of delay, matching an adder node.
    always_ff @(posedge clk) begin
        q <= d;
    end

endmodule

// File: rtl/sst_deskew.sv
// Output deskew: low slice j is delayed N_SLICES-1-j cycles so that all
// slices of one sum arrive together with the top slice.
// Assumes: N_SLICES >= 2; the top slice passes through unregistered
// (it comes straight from the root register).
module sst_deskew #(
    parameter int SLICE_W  = 3,
    parameter int N_SLICES = 3,
    parameter int WORD_W   = 12
) (
    input  logic              clk,
    input  logic [WORD_W-1:0] skewed,
    output logic [WORD_W-1:0] aligned
);
    localparam int TOP_LO = (N_SLICES - 1) * SLICE_W;

    for (genvar j = 0; j < N_SLICES - 1; j++) begin : g_sl
        localparam int DLY = N_SLICES - 1 - j;
        logic [SLICE_W-1:0] dq [DLY];

        // Delay line that lines slice j up with the top slice.
        always_ff @(posedge clk) begin
            dq[0] <= skewed[j*SLICE_W +: SLICE_W];
            for (int m = 1; m < DLY; m++) begin
                dq[m] <= dq[m-1];
            end
        end

        assign aligned[j*SLICE_W +: SLICE_W] = dq[DLY-1];
    end

    assign aligned[WORD_W-1:TOP_LO] = skewed[WORD_W-1:TOP_LO];

endmodule

// File: rtl/sliced_sum_tree.sv
// Multi-operand unsigned adder tree with carry-pipelined slices.
// Operands are skewed at entry, summed pairwise by N_OPS-1 sliced adders
// (an unpaired word at a level is carried by a register), and deskewed
// at the root. Latency is ceil(log2 N_OPS) + N_SLICES cycles and a set
// is accepted every cycle. Only the valid pipeline is reset.
// Assumes: N_OPS >= 2, N_SLICES >= 2, SLICE_W >= 1.
module sliced_sum_tree
    import sst_pkg::*;
#(
    parameter  int N_OPS    = 5,
    parameter  int SLICE_W  = 3,
    parameter  int N_SLICES = 3,
    localparam int OP_W     = SLICE_W * N_SLICES,
    localparam int DEPTH    = $clog2(N_OPS),
    localparam int RES_W    = OP_W + DEPTH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [N_OPS*OP_W-1:0] in_ops,
    output logic                  sum_valid,
    output logic [RES_W-1:0]      sum_data
);
    localparam int LAT = DEPTH + N_SLICES;

    logic [RES_W-1:0] lvl_q [DEPTH+1][N_OPS];
    logic [LAT-1:0]   vld_q;

    // Leaves: skew every operand into wavefront form.
    for (genvar i = 0; i < N_OPS; i++) begin : g_leaf
        sst_skew_in #(
            .SLICE_W (SLICE_W),
            .N_SLICES(N_SLICES),
            .WORD_W  (RES_W)
        ) u_skew (
            .clk (clk),
            .op  (in_ops[i*OP_W +: OP_W]),
            .word(lvl_q[0][i])
        );
    end

    // Tree levels: pair nodes, carry an odd one up by a register.
    for (genvar l = 1; l <= DEPTH; l++) begin : g_lvl
        localparam int CNT  = level_nodes(N_OPS, l);
        localparam int PCNT = level_nodes(N_OPS, l - 1);
        for (genvar i = 0; i < N_OPS; i++) begin : g_nd
            if (i < CNT && (2 * i + 1) < PCNT) begin : g_add
                sst_node #(
                    .SLICE_W (SLICE_W),
                    .N_SLICES(N_SLICES),
                    .WORD_W  (RES_W)
                ) u_node (
                    .clk(clk),
                    .a  (lvl_q[l-1][2*i]),
                    .b  (lvl_q[l-1][2*i+1]),
                    .y  (lvl_q[l][i])
                );
            end else if (i < CNT) begin : g_pass
                sst_delay #(
                    .WORD_W(RES_W)
                ) u_pass (
                    .clk(clk),
                    .d  (lvl_q[l-1][2*i]),
                    .q  (lvl_q[l][i])
                );
            end else begin : g_none
                assign lvl_q[l][i] = '0;
            end
        end
    end

    // Root: realign slices into a full-width sum.
    sst_deskew #(
        .SLICE_W (SLICE_W),
        .N_SLICES(N_SLICES),
        .WORD_W  (RES_W)
    ) u_deskew (
        .clk    (clk),
        .skewed (lvl_q[DEPTH][0]),
        .aligned(sum_data)
    );

    // Valid flag pipeline matching the data latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= {vld_q[LAT-2:0], in_valid};
        end
    end

    assign sum_valid = vld_q[LAT-1];

endmodule

// File: rtl/sst_checker.sv
// Property checker for sliced_sum_tree. Keeps a behavioural sum and
// valid history at the block's ports and compares the outputs with it.
// Assumes: bound to the top module with its default or overridden
// parameters.
module sst_checker #(
    parameter int N_OPS    = 5,
    parameter int SLICE_W  = 3,
    parameter int N_SLICES = 3
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   in_valid,
    input logic [N_OPS*SLICE_W*N_SLICES-1:0]      in_ops,
    input logic                                   sum_valid,
    input logic [SLICE_W*N_SLICES+$clog2(N_OPS)-1:0] sum_data
);
    localparam int OP_W  = SLICE_W * N_SLICES;
    localparam int DEPTH = $clog2(N_OPS);
    localparam int RES_W = OP_W + DEPTH;
    localparam int LAT   = DEPTH + N_SLICES;
    localparam logic [63:0] MAX_SUM = 64'(N_OPS) * ((64'd1 << OP_W) - 64'd1);

    logic [RES_W-1:0] ref_sum;
    logic [LAT-1:0]   mv_q;
    logic [RES_W-1:0] ms_q [LAT];

    // Behavioural sum of the present operand set.
    always_comb begin
        ref_sum = '0;
        for (int i = 0; i < N_OPS; i++) begin
            ref_sum = ref_sum + RES_W'(in_ops[i*OP_W +: OP_W]);
        end
    end

    // Reference history of valid flags and sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mv_q <= '0;
        end else begin
            mv_q <= {mv_q[LAT-2:0], in_valid};
        end
        ms_q[0] <= ref_sum;
        for (int m = 1; m < LAT; m++) begin
            ms_q[m] <= ms_q[m-1];
        end
    end

    // R1: every reported sum equals the reference sum.
    a_r1_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> (sum_data == ms_q[LAT-1]));

    // R1: a reported sum never exceeds the largest reachable value.
    a_r1_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> (64'(sum_data) <= MAX_SUM));

    // R2: the result flag follows the input flag by exactly LAT cycles.
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid == mv_q[LAT-1]);

    // R6: the first cycle after reset release shows no result.
    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sum_valid);

endmodule

bind sliced_sum_tree sst_checker #(
    .N_OPS   (N_OPS),
    .SLICE_W (SLICE_W),
    .N_SLICES(N_SLICES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ops   (in_ops),
    .sum_valid(sum_valid),
    .sum_data (sum_data)
);

// File: tb/sim_sliced_sum_tree.sv
// Self-checking bench for sliced_sum_tree at default parameters.
module sim_sliced_sum_tree;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 5;
    localparam int SW    = 3;
    localparam int NS    = 3;
    localparam int OW    = SW * NS;
    localparam int RW    = OW + $clog2(N);
    localparam int LAT   = $clog2(N) + NS;
    localparam int MAXOP = (1 << OW) - 1;
    localparam int NV    = 10;

    // Entry = {expected sum, op4, op3, op2, op1, op0}.
    localparam logic [RW+N*OW-1:0] TBL [NV] = '{
        {12'd0,    9'd0,   9'd0,   9'd0,   9'd0,   9'd0},
        {12'd2555, 9'd511, 9'd511, 9'd511, 9'd511, 9'd511},
        {12'd15,   9'd5,   9'd4,   9'd3,   9'd2,   9'd1},
        {12'd35,   9'd7,   9'd7,   9'd7,   9'd7,   9'd7},
        {12'd64,   9'd0,   9'd0,   9'd0,   9'd1,   9'd63},
        {12'd511,  9'd511, 9'd0,   9'd0,   9'd0,   9'd0},
        {12'd1022, 9'd0,   9'd0,   9'd0,   9'd511, 9'd511},
        {12'd1280, 9'd256, 9'd256, 9'd256, 9'd256, 9'd256},
        {12'd1500, 9'd500, 9'd400, 9'd300, 9'd200, 9'd100},
        {12'd1533, 9'd511, 9'd0,   9'd511, 9'd0,   9'd511}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [N*OW-1:0] in_ops;
    logic            sum_valid;
    logic [RW-1:0]   sum_data;

    int    cyc   = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    exp_q[$];
    int    iss_q[$];
    string tag_q[$];
    int    mon_e;
    int    mon_i;
    string mon_t;

    sliced_sum_tree #(.N_OPS(N), .SLICE_W(SW), .N_SLICES(NS)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ops   (in_ops),
        .sum_valid(sum_valid),
        .sum_data (sum_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ref_sum(input logic [N*OW-1:0] ops);
        int s;
        s = 0;
        for (int i = 0; i < N; i++) s += int'(ops[i*OW +: OW]);
        return s;
    endfunction

    function automatic logic [N*OW-1:0] rand_ops();
        logic [N*OW-1:0] o;
        for (int i = 0; i < N; i++) begin
            o[i*OW +: OW] = ($urandom_range(3, 0) == 0) ? OW'(MAXOP)
                                                        : OW'($urandom_range(MAXOP, 0));
        end
        return o;
    endfunction

    task automatic send(input logic [N*OW-1:0] ops, input int exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_ops   = ops;
        exp_q.push_back(exp);
        iss_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic [N*OW-1:0] junk);
        @(negedge clk);
        in_valid = 1'b0;
        in_ops   = junk;
    endtask

    // Monitor: compare each result with the oldest outstanding set.
    always @(negedge clk) begin
        if (rst_n && sum_valid) begin
            if (exp_q.size() == 0) begin
                check("R4 result without an accepted set", 1, 0);
            end else begin
                mon_e = exp_q.pop_front();
                mon_i = iss_q.pop_front();
                mon_t = tag_q.pop_front();
                check(mon_t, int'(sum_data), mon_e);
                check("R2 latency", cyc - mon_i, LAT);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R6: reset with valid input asserted.
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_ops   = '1;
        repeat (3) begin
            @(negedge clk);
            check("R6 sum_valid low in reset", int'(sum_valid), 0);
        end
        @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        in_ops   = '0;
        repeat (LAT + 2) begin
            @(negedge clk);
            check("R6 no result from reset-time input", int'(sum_valid), 0);
        end

        // Table walk, back to back (R1, R3, R5, R7).
        for (int v = 0; v < NV; v++) begin
            string t;
            t = (v == 1 || v == 4) ? "R5 carry across slices"
              : (v == 5)           ? "R7 unpaired operand"
              :                      "R1 table sum";
            send(TBL[v][N*OW-1:0], int'(TBL[v][RW+N*OW-1:N*OW]), t);
        end
        repeat (LAT + 1) idle('0);

        // R4: bubbles carrying garbage operands.
        for (int k = 0; k < 16; k++) begin
            logic [N*OW-1:0] o;
            o = rand_ops();
            if (k % 3 == 0) send(o, ref_sum(o), "R4 sum beside bubbles");
            else            idle(o);
        end
        repeat (LAT + 1) idle('1);

        // R7: one all-ones operand at each position.
        for (int p = 0; p < N; p++) begin
            logic [N*OW-1:0] o;
            o = '0;
            o[p*OW +: OW] = OW'(MAXOP);
            send(o, MAXOP, "R7 operand position weight");
        end

        // R3: long random stream, one set per cycle.
        for (int k = 0; k < 300; k++) begin
            logic [N*OW-1:0] o;
            o = rand_ops();
            send(o, ref_sum(o), "R3 streaming sum");
        end
        repeat (LAT + 2) idle('0);
        check("R3 every set returned", exp_q.size(), 0);

        // R6: reset while sets are in flight.
        for (int k = 0; k < 3; k++) begin
            logic [N*OW-1:0] o;
            o = rand_ops();
            send(o, ref_sum(o), "R6 set before reset");
        end
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b1;
        exp_q.delete();
        iss_q.delete();
        tag_q.delete();
        repeat (2) begin
            @(negedge clk);
            check("R6 sum_valid low in reset", int'(sum_valid), 0);
        end
        rst_n    = 1'b1;
        in_valid = 1'b0;
        repeat (LAT + 2) begin
            @(negedge clk);
            check("R6 in-flight set discarded", int'(sum_valid), 0);
        end

        // Recovery after reset.
        send(TBL[1][N*OW-1:0], int'(TBL[1][RW+N*OW-1:N*OW]), "R5 all ones after reset");
        repeat (LAT + 2) idle('0);
        check("R3 every set returned after reset", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule